// File: doc/BRIEF.md
# Two-Wire Bus Input Conditioner

This block cleans up the two raw lines of a two-wire serial bus (a data line and a clock line, I2C style) before the protocol state machines of a bus controller see them. Both lines are treated as plain data. Each one is brought into the system clock domain through two flip-flops. It can then pass through a glitch filter that is switched on by a configuration input. The filter ignores any pulse shorter than `FILT_LEN` clocks.

From the clean levels the block derives several one-cycle events:

- rising and falling edges of the bus clock line;
- start conditions, where the data line falls while the clock line is high;
- stop conditions, where the data line rises while the clock line is high.

The data line is not sampled on the clock-line rising edge itself. A sample strobe fires a programmable number of system clocks after that edge, which gives extra noise immunity. The captured bit is then held on an output until the next strobe.

The controller samples the clean levels and event pulses every system clock. It sets the filter enable and the sample delay as static configuration.

Top module: `twi_line_cond`

## Requirements
- R1: While `rst` is high, and after it, until the bus moves, `sda_o`, `scl_o` and `samp_bit` are 1 and `scl_rise`, `scl_fall`, `start_det`, `stop_det`, `samp_strobe` are 0.
- R2: Each raw line passes through exactly two synchronizing flip-flops. With the filter off, a raw change set up before clock edge k is visible on the clean output from the cycle that follows edge k+1.
- R3: With `filt_en`=1, a clean output changes only after the synchronized input has held the new level for `FILT_LEN` consecutive clocks. This adds `FILT_LEN` cycles to the latency of R2. A raw pulse of `FILT_LEN`-1 clocks or fewer produces no output change and no event.
- R4: With `filt_en`=0, no filtering takes place: a raw pulse of a single clock reaches the clean output and its events.
- R5: `scl_rise` (or `scl_fall`) is high for exactly the one cycle in which `scl_o` first shows 1 (or 0). The two pulses are never high together.
- R6: `start_det` pulses in the cycle in which `sda_o` falls while `scl_o` was and is high. `stop_det` pulses in the cycle in which `sda_o` rises under the same condition.
- R7: `samp_strobe` pulses `samp_dly` cycles after the cycle of `scl_rise`, where `samp_dly` is a 4-bit unsigned count. With `samp_dly`=0 it pulses in the same cycle as `scl_rise`.
- R8: From the cycle after `samp_strobe`, `samp_bit` holds the value that `sda_o` had in the strobe cycle, until the next strobe.
- R9: An `scl_rise` that arrives while an earlier delayed sample is still pending restarts the delay. The earlier sample never fires.
- R10: A change of `sda_o` while `scl_o` is low produces neither `start_det` nor `stop_det`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_raw | input | 1 | Raw data line from the pad |
| scl_raw | input | 1 | Raw bus clock line from the pad |
| filt_en | input | 1 | 1 = glitch filter on, 0 = bypass |
| samp_dly | input | 4 | Clocks from clock-line rise to data sample |
| sda_o | output | 1 | Clean data line level |
| scl_o | output | 1 | Clean bus clock line level |
| scl_rise | output | 1 | One-cycle pulse on clean clock-line rise |
| scl_fall | output | 1 | One-cycle pulse on clean clock-line fall |
| start_det | output | 1 | One-cycle start condition pulse |
| stop_det | output | 1 | One-cycle stop condition pulse |
| samp_strobe | output | 1 | One-cycle delayed data sample strobe |
| samp_bit | output | 1 | Last sampled data bit |

## Verification
The bench drives the following filter cases, each with its expected outcome:

| Case | Filter | Expected outcome | Symptom of a faulty design |
|---|---|---|---|
| Raw pulse of `FILT_LEN`-1 clocks | on | No output change, no event | Spurious clock edges |
| Raw pulse of exactly `FILT_LEN` clocks | on | Edges appear | Off-by-one counter either drops them or shifts their cycle |
| Single-clock glitch | off | Full fall and rise pulses | Filter that cannot be bypassed swallows them |

The sample delay is exercised at 0, at the maximum of 15 and at mid values. A design that counts one cycle too many or too few, or that always waits at least one cycle, strobes in the wrong cycle.

A second clock-line rise is made to land inside a pending delay. A design without the restart fires twice, or fires at the stale time.

Data-line changes are made both under a high and under a low clock line. A design that ignores the clock-line level reports false start or stop conditions.

// File: rtl/twi_cond_pkg.sv
package twi_cond_pkg;

  // Bit positions inside the two-line bundle.
  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
  localparam int unsigned N_LINES  = 2;

  // True once a disagreeing input has been seen for the full filter length.
  function automatic bit filt_done(input int cnt, input int len);
    return cnt >= len - 1;
  endfunction

  // Counter value loaded on a clock-line rise for a nonzero delay.
  function automatic int dly_reload(input int dly);
    return (dly > 0) ? dly - 1 : 0;
  endfunction

  // Clocks from a raw change to the clean output.
  function automatic int line_latency(input bit filt_on, input int len);
    return filt_on ? 2 + len : 2;
  endfunction

endpackage

// File: rtl/twi_sync2.sv
module twi_sync2 #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] rank1;
  logic [W-1:0] rank2;
  logic [1:0]   warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      rank1 <= '1;
      rank2 <= '1;
    end else begin
      rank1 <= d;
      rank2 <= rank1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  assign q = rank2;

  // R2: output equals the input of two edges earlier, once both ranks are loaded
  assert_sync_depth_R2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/twi_glitch_filt.sv
module twi_glitch_filt
  import twi_cond_pkg::*;
#(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

  logic          held;
  logic [CW-1:0] run_cnt;
  logic          differs;
  logic          settle;

  assign differs = (din != held);
  assign settle  = differs && filt_done(int'(run_cnt), int'(FILT_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b1;
      run_cnt <= '0;
    end else if (!en) begin
      held    <= din;
      run_cnt <= '0;
    end else if (!differs) begin
      run_cnt <= '0;
    end else if (settle) begin
      held    <= din;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign dout = en ? held : din;

  // R3: while filtering, the held level moves only after a full run of disagreement
  assert_filt_settle_R3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (held != $past(held))) |-> ($past(run_cnt) == CW'(FILT_LEN - 1)));

  // R3: an agreeing input leaves the held level alone
  assert_filt_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && ($past(din) == $past(held))) |-> $stable(held));

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic sda,
  input  logic scl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic sda_prev;
  logic scl_prev;
  logic scl_steady_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_prev <= 1'b1;
      scl_prev <= 1'b1;
    end else begin
      sda_prev <= sda;
      scl_prev <= scl;
    end
  end

  assign scl_steady_hi = scl && scl_prev;
  assign scl_rise      = scl && !scl_prev;
  assign scl_fall      = !scl && scl_prev;
  assign start_det     = scl_steady_hi && sda_prev && !sda;
  assign stop_det      = scl_steady_hi && !sda_prev && sda;

  // R5: the clock-line edge pulses never coincide
  assert_edge_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_rise, scl_fall}));

  // R5: a rise pulse lasts one cycle
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
    scl_rise |=> !scl_rise);

  // R6: a condition pulse needs the clean clock line high
  assert_cond_scl_hi_R6: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |-> scl);

  // R10: no condition pulse unless the clock line was already high
  assert_cond_prev_hi_R10: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |-> scl_prev);

  // R6: start and stop never together
  assert_cond_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(start_det && stop_det));

endmodule

// File: rtl/twi_sample_timer.sv
module twi_sample_timer
  import twi_cond_pkg::*;
#(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             sda,
  input  logic [DLY_W-1:0] dly,
  output logic             strobe,
  output logic             samp_bit
);
  logic             pending;
  logic [DLY_W-1:0] remain;
  logic             dly_zero;

  assign dly_zero = (dly == '0);
  // A fresh rise restarts the count; the old sample is dropped.
  assign strobe   = scl_rise ? dly_zero : (pending && (remain == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      remain  <= '0;
    end else if (scl_rise) begin
      pending <= !dly_zero;
      remain  <= DLY_W'(dly_reload(int'(dly)));
    end else if (pending) begin
      if (remain == '0) pending <= 1'b0;
      else              remain  <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         samp_bit <= 1'b1;
    else if (strobe) samp_bit <= sda;
  end

  // R7: zero delay samples in the rise cycle
  assert_zero_dly_R7: assert property (@(posedge clk) disable iff (rst)
    (scl_rise && dly_zero) |-> strobe);

  // R7: no strobe without a rise or a pending sample
  assert_no_idle_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (!pending && !scl_rise) |-> !strobe);

  // R9: a rise with a nonzero delay never fires an older sample
  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (scl_rise && !dly_zero) |-> !strobe);

  // R8: the captured bit is the data level of the strobe cycle
  assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (samp_bit == $past(sda)));

  // R8: the captured bit holds between strobes
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(samp_bit));

endmodule

// File: rtl/twi_line_cond.sv
module twi_line_cond
  import twi_cond_pkg::*;
#(
  parameter int unsigned FILT_LEN = 3,
  parameter int unsigned DLY_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_raw,
  input  logic             scl_raw,
  input  logic             filt_en,
  input  logic [DLY_W-1:0] samp_dly,
  output logic             sda_o,
  output logic             scl_o,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             start_det,
  output logic             stop_det,
  output logic             samp_strobe,
  output logic             samp_bit
);
  logic [N_LINES-1:0] raw_bus;
  logic [N_LINES-1:0] sync_bus;
  logic [N_LINES-1:0] clean_bus;

  always_comb begin
    raw_bus           = '0;
    raw_bus[LINE_SCL] = scl_raw;
    raw_bus[LINE_SDA] = sda_raw;
  end

  twi_sync2 #(.W(N_LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (sync_bus)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    twi_glitch_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .en   (filt_en),
      .din  (sync_bus[g]),
      .dout (clean_bus[g])
    );
  end

  assign sda_o = clean_bus[LINE_SDA];
  assign scl_o = clean_bus[LINE_SCL];

  twi_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .sda       (sda_o),
    .scl       (scl_o),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_sample_timer #(.DLY_W(DLY_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .sda      (sda_o),
    .dly      (samp_dly),
    .strobe   (samp_strobe),
    .samp_bit (samp_bit)
  );

  // R1: reset leaves all events quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !(scl_rise || scl_fall || start_det || stop_det || samp_strobe));

  // R1: reset drives the clean levels to an idle bus
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (sda_o && scl_o && samp_bit));

endmodule

// File: tb/twi_line_cond_test.sv
module twi_line_cond_test;
  localparam int L = 3;
  localparam int K_RISE = 0, K_FALL = 1, K_START = 2, K_STOP = 3, K_STRB = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sda_raw = 1'b1, scl_raw = 1'b1, filt_en = 1'b0;
  logic [3:0] samp_dly = 4'd0;
  logic sda_o, scl_o, scl_rise, scl_fall, start_det, stop_det, samp_strobe, samp_bit;

  twi_line_cond #(.FILT_LEN(L), .DLY_W(4)) uut (
    .clk(clk), .rst(rst), .sda_raw(sda_raw), .scl_raw(scl_raw),
    .filt_en(filt_en), .samp_dly(samp_dly), .sda_o(sda_o), .scl_o(scl_o),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .samp_strobe(samp_strobe), .samp_bit(samp_bit));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int kind; int at; logic bitv; string req; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  logic m_sda = 1'b1, m_scl = 1'b1;
  bit mon_on = 1'b0, done = 1'b0;
  bit bit_pend = 1'b0;
  logic bit_exp = 1'b1;

  function automatic string kname(int k);
    case (k)
      K_RISE:  return "scl_rise";
      K_FALL:  return "scl_fall";
      K_START: return "start_det";
      K_STOP:  return "stop_det";
      default: return "samp_strobe";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic push(int k, int at, logic b, string req);
    exp_t e;
    e.kind = k; e.at = at; e.bitv = b; e.req = req;
    q.push_back(e);
  endtask

  // Driver: changes the raw lines and forecasts the resulting events.
  task automatic drive(logic s_sda, logic s_scl, bit expect_ev, bit want_strobe);
    int at;
    at = cyc + 2 + (filt_en ? L : 0);
    if (expect_ev) begin
      if (s_scl && !m_scl) begin
        push(K_RISE, at, 1'b0, "R5");
        if (want_strobe) push(K_STRB, at + int'(samp_dly), s_sda, "R7");
      end
      if (!s_scl && m_scl) push(K_FALL, at, 1'b0, "R5");
      if (!s_sda && m_sda && m_scl && s_scl) push(K_START, at, 1'b0, "R6");
      if (s_sda && !m_sda && m_scl && s_scl) push(K_STOP, at, 1'b0, "R6");
    end
    sda_raw = s_sda; scl_raw = s_scl;
    m_sda = s_sda;   m_scl = s_scl;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_levels(string req);
    check(sda_o == m_sda, req, "sda_o level", int'(sda_o), int'(m_sda));
    check(scl_o == m_scl, req, "scl_o level", int'(scl_o), int'(m_scl));
  endtask

  task automatic match(int k);
    int idx = -1;
    for (int i = 0; i < q.size(); i++)
      if (idx < 0 && q[i].kind == k && q[i].at == cyc) idx = i;
    if (idx < 0) begin
      check(1'b0, (k == K_STRB) ? "R9" : "R3", {"unexpected ", kname(k)}, 1, 0);
    end else begin
      check(1'b1, q[idx].req, kname(k), 1, 1);
      if (k == K_STRB) begin
        check(sda_o == q[idx].bitv, "R8", "sda_o at strobe", int'(sda_o), int'(q[idx].bitv));
        bit_pend = 1'b1;
        bit_exp  = q[idx].bitv;
      end
      q.delete(idx);
    end
  endtask

  // Monitor: pops each observed event against the forecast.
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (bit_pend) begin
        bit_pend = 1'b0;
        check(samp_bit == bit_exp, "R8", "samp_bit", int'(samp_bit), int'(bit_exp));
      end
      if (scl_rise)    match(K_RISE);
      if (scl_fall)    match(K_FALL);
      if (start_det)   match(K_START);
      if (stop_det)    match(K_STOP);
      if (samp_strobe) match(K_STRB);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    step(3);
    // R1: reset state
    check(sda_o && scl_o, "R1", "levels in reset", int'({sda_o, scl_o}), 3);
    check(!(scl_rise || scl_fall || start_det || stop_det || samp_strobe), "R1",
          "pulses in reset", int'({scl_rise, scl_fall, start_det, stop_det, samp_strobe}), 0);
    check(samp_bit == 1'b1, "R1", "samp_bit in reset", int'(samp_bit), 1);
    rst = 1'b0;
    mon_on = 1'b1;
    step(4);
    check(samp_bit == 1'b1 && sda_o && scl_o, "R1", "idle after reset",
          int'({samp_bit, sda_o, scl_o}), 7);

    // Bypass, delay 2: start, bits 1 and 0, stop (R2 R6 R7 R10)
    samp_dly = 4'd2;
    drive(1'b0, 1'b1, 1, 1); step(1);
    check(sda_o == 1'b1, "R2", "sda_o one cycle after change", int'(sda_o), 1);
    step(1);
    check(sda_o == 1'b0, "R2", "sda_o two cycles after change", int'(sda_o), 0);
    step(4);
    drive(1'b0, 1'b0, 1, 1); step(6);
    drive(1'b1, 1'b0, 1, 1); step(4);   // R10: data moves under low clock
    drive(1'b1, 1'b1, 1, 1); step(8);
    drive(1'b1, 1'b0, 1, 1); step(4);
    drive(1'b0, 1'b0, 1, 1); step(4);   // R10
    drive(1'b0, 1'b1, 1, 1); step(8);
    drive(1'b1, 1'b1, 1, 1); step(6);   // stop
    check_levels("R2");

    // Delay 0: strobe in the rise cycle (R7)
    samp_dly = 4'd0;
    drive(1'b1, 1'b0, 1, 1); step(4);
    drive(1'b0, 1'b0, 1, 1); step(4);
    drive(1'b0, 1'b1, 1, 1); step(6);
    // Maximum delay 15 (R7)
    drive(1'b0, 1'b0, 1, 1); step(4);
    samp_dly = 4'd15;
    drive(1'b1, 1'b0, 1, 1); step(4);
    drive(1'b1, 1'b1, 1, 1); step(22);

    // Restart: second rise inside a pending delay (R9)
    samp_dly = 4'd5;
    drive(1'b1, 1'b0, 1, 1); step(6);
    drive(1'b1, 1'b1, 1, 0); step(2);
    drive(1'b1, 1'b0, 1, 1); step(1);
    drive(1'b1, 1'b1, 1, 1); step(12);
    check_levels("R9");

    // Bypass passes a one-clock glitch (R4)
    drive(1'b1, 1'b0, 1, 1); step(1);
    drive(1'b1, 1'b1, 1, 1); step(12);
    check_levels("R4");

    // Filter on (R3)
    filt_en = 1'b1; step(4);
    drive(1'b1, 1'b0, 0, 0); step(L - 1);     // too short: ignored
    drive(1'b1, 1'b1, 0, 0); step(12);
    check_levels("R3");
    drive(1'b0, 1'b1, 0, 0); step(1);         // short data glitch: no start
    drive(1'b1, 1'b1, 0, 0); step(12);
    check_levels("R3");
    samp_dly = 4'd3;
    drive(1'b1, 1'b0, 1, 1); step(L);         // exactly long enough
    drive(1'b1, 1'b1, 1, 1); step(14);
    check_levels("R3");
    // Filtered transaction: start, bit 0, stop
    drive(1'b0, 1'b1, 1, 1); step(10);
    drive(1'b0, 1'b0, 1, 1); step(10);
    drive(1'b0, 1'b1, 1, 1); step(12);
    drive(1'b1, 1'b1, 1, 1); step(12);
    check_levels("R6");

    step(30);
    while (q.size() > 0) begin
      check(1'b0, q[0].req, {"missing ", kname(q[0].kind)}, 0, q[0].at);
      void'(q.pop_front());
    end
    finish_run();
  end

endmodule